// File: doc/BRIEF.md
# I2C Slave Byte Engine with Selectable Stretch Point

This block is the receive side of an I2C slave. It oversamples the bus clock and data lines on the system clock, recognises start and stop conditions, shifts in the address byte and the data bytes that follow, and decides whether to acknowledge each byte. At a wait point it holds SCL low and pulses an interrupt. The master stays stalled until software pulses the wait-release input.

Software programs the block through static configuration inputs. One input turns the interface on. Another selects whether data bytes stall after the eighth or the ninth falling SCL edge. The others are an acknowledge enable, a stop-interrupt enable, a wake-up mode and the 7-bit local address. Address bytes do not follow the programmed wait point. A matching address always stalls after its acknowledge, and an extension code always stalls one edge earlier. The last complete byte is presented on `rxByte` so that software can read it during the stall.

Top module: `i2c_wait_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) begins address reception from the first bit, including a repeated start in the middle of a byte. A stop condition (SDA rising while SCL is high) returns the block to idle.
- R2: At each wait point the block raises `sclHoldLow` and pulses `waitIrq` high for one cycle. `sclHoldLow` stays high until `waitRelease` is pulsed.
- R3: When bits 7..1 of the address byte equal `localAddr`, the slave acknowledges during the ninth clock whatever `cfgAckEnable` says. It then waits and interrupts on the ninth falling edge whatever `cfgWaitNinth` says.
- R4: When the address byte does not match and its top four bits are 1111 (an extension code), the wait and interrupt come on the eighth falling edge. The acknowledge is given only if `cfgAckEnable` is 1.
- R5: Any other address is not acknowledged and causes no wait and no interrupt, on that byte or on any later byte, until the next start condition.
- R6: After an acknowledged or extension address, each data byte waits and interrupts on the eighth falling edge when `cfgWaitNinth` is 0, and on the ninth when it is 1.
- R7: For data bytes, SDA is pulled low through the ninth clock exactly when `cfgAckEnable` is 1.
- R8: A stop condition pulses `stopIrq` only when `cfgStopIrqEn` is 1 and `cfgWakeMode` is 0.
- R9: While `cfgEnable` is 0, the block drives neither line and raises no interrupt, whatever the other settings are.
- R10: `rxByte` holds the last complete byte, MSB first. For an address byte, bit 0 is the read/write flag. The value is stable during the wait that follows the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| cfgEnable | input | 1 | Interface enable |
| cfgWaitNinth | input | 1 | Data-byte wait point: 0 = eighth falling edge, 1 = ninth |
| cfgAckEnable | input | 1 | Acknowledge data bytes and extension codes |
| cfgStopIrqEn | input | 1 | Allow an interrupt on a stop condition |
| cfgWakeMode | input | 1 | Wake-up mode; suppresses the stop interrupt |
| localAddr | input | 7 | Own 7-bit slave address |
| waitRelease | input | 1 | One-cycle pulse that ends a wait |
| sdaDriveLow | output | 1 | Pull SDA low (open-drain enable) |
| sclHoldLow | output | 1 | Pull SCL low (clock stretch) |
| waitIrq | output | 1 | One-cycle pulse at each wait point |
| stopIrq | output | 1 | One-cycle pulse on a qualified stop condition |
| rxByte | output | 8 | Last complete received byte |

## Verification
The assertions assume the following about the inputs:
- `waitRelease` is pulsed only while SCL is being held low, so no SCL edge falls in the same cycle.
- The master never drives a start or stop condition while the block is stretching the clock.
- SCL and SDA each stay stable for many system clocks between transitions.

The bench master obeys these rules by construction. It models both lines as wired-AND. It waits ten system clocks per bus phase, and it releases a wait only after it has seen `sclHoldLow` with SCL low. The stimulus covers:
- every combination of wait select and acknowledge enable, against four address kinds (match-write, match-read, extension, foreign), each followed by a data byte and a stop;
- all four combinations of stop-interrupt enable and wake-up mode;
- a disabled-interface pass;
- a repeated start in the middle of a byte.

// File: rtl/i2cws_pkg.sv
package i2cws_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_SKIP
  } busPhase_t;

  // datapath -> control: qualified bus events
  typedef struct packed {
    logic startSeen;
    logic stopSeen;
    logic sclFall;
  } busEvents_t;

  // control -> datapath: strobes
  typedef struct packed {
    logic clearCount;
    logic latchByte;
  } ctlStrobes_t;

endpackage

// File: rtl/i2cws_datapath.sv
module i2cws_datapath
  import i2cws_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_BITS   = 7
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  input  ctlStrobes_t            strobes,
  output busEvents_t             events,
  output logic [$clog2(ADDR_BITS+3)-1:0] riseCnt,
  output logic [ADDR_BITS-1:0]   addrField,
  output logic [ADDR_BITS:0]     rxByte
);
  localparam int BYTE_BITS = ADDR_BITS + 1;
  localparam int CNT_W     = $clog2(ADDR_BITS + 3);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic                   sclLast, sdaLast;
  logic                   sclNow, sdaNow, sclRise;
  logic [BYTE_BITS-1:0]   shiftReg;

  // one synchronizer chain per bus line
  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
    end
  endgenerate

  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclLast <= 1'b1;
      sdaLast <= 1'b1;
    end else begin
      sclLast <= sclNow;
      sdaLast <= sdaNow;
    end

  assign sclRise          = sclNow & ~sclLast;
  assign events.sclFall   = ~sclNow & sclLast;
  assign events.startSeen = sclNow & sclLast & sdaLast & ~sdaNow;
  assign events.stopSeen  = sclNow & sclLast & ~sdaLast & sdaNow;

  // rising-edge counter: 1..8 data bits, 9 = acknowledge clock
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)
      riseCnt <= '0;
    else if (strobes.clearCount)
      riseCnt <= '0;
    else if (sclRise && riseCnt < CNT_W'(BYTE_BITS + 1))
      riseCnt <= riseCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)
      shiftReg <= '0;
    else if (sclRise && riseCnt < CNT_W'(BYTE_BITS))
      shiftReg <= {shiftReg[BYTE_BITS-2:0], sdaNow};

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)
      rxByte <= '0;
    else if (strobes.latchByte)
      rxByte <= shiftReg;

  assign addrField = shiftReg[BYTE_BITS-1:1];

endmodule

// File: rtl/i2cws_control.sv
module i2cws_control
  import i2cws_pkg::*;
#(
  parameter int ADDR_BITS = 7,
  parameter int EXT_BITS  = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgEnable,
  input  logic                   cfgWaitNinth,
  input  logic                   cfgAckEnable,
  input  logic                   cfgStopIrqEn,
  input  logic                   cfgWakeMode,
  input  logic [ADDR_BITS-1:0]   localAddr,
  input  logic                   waitRelease,
  input  busEvents_t             events,
  input  logic [$clog2(ADDR_BITS+3)-1:0] riseCnt,
  input  logic [ADDR_BITS-1:0]   addrField,
  output ctlStrobes_t            strobes,
  output logic                   sdaDriveLow,
  output logic                   sclHoldLow,
  output logic                   waitIrq,
  output logic                   stopIrq
);
  localparam int BYTE_BITS = ADDR_BITS + 1;
  localparam int CNT_W     = $clog2(ADDR_BITS + 3);

  busPhase_t phase;
  logic      addrMatched;
  logic      fallLast, fallAck, isMatch, isExt;

  assign fallLast = events.sclFall && (riseCnt == CNT_W'(BYTE_BITS));
  assign fallAck  = events.sclFall && (riseCnt == CNT_W'(BYTE_BITS + 1));
  assign isMatch  = (addrField == localAddr);
  assign isExt    = (addrField[ADDR_BITS-1 -: EXT_BITS] == '1);

  assign strobes.clearCount = ~cfgEnable | events.startSeen | events.stopSeen | fallAck;
  assign strobes.latchByte  = cfgEnable & fallLast & ((phase == PH_ADDR) | (phase == PH_DATA));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      phase       <= PH_IDLE;
      addrMatched <= 1'b0;
      sdaDriveLow <= 1'b0;
      sclHoldLow  <= 1'b0;
      waitIrq     <= 1'b0;
      stopIrq     <= 1'b0;
    end else if (!cfgEnable) begin
      phase       <= PH_IDLE;
      addrMatched <= 1'b0;
      sdaDriveLow <= 1'b0;
      sclHoldLow  <= 1'b0;
      waitIrq     <= 1'b0;
      stopIrq     <= 1'b0;
    end else begin
      waitIrq <= 1'b0;
      stopIrq <= 1'b0;
      if (waitRelease) sclHoldLow <= 1'b0;

      if (events.stopSeen) begin
        phase       <= PH_IDLE;
        sdaDriveLow <= 1'b0;
        sclHoldLow  <= 1'b0;
        stopIrq     <= cfgStopIrqEn & ~cfgWakeMode;
      end else if (events.startSeen) begin
        phase       <= PH_ADDR;
        sdaDriveLow <= 1'b0;
        sclHoldLow  <= 1'b0;
      end else if (fallLast) begin
        unique case (phase)
          PH_ADDR: begin
            if (isMatch) begin
              addrMatched <= 1'b1;
              sdaDriveLow <= 1'b1;
            end else if (isExt) begin
              addrMatched <= 1'b0;
              sdaDriveLow <= cfgAckEnable;
              sclHoldLow  <= 1'b1;
              waitIrq     <= 1'b1;
            end else begin
              phase <= PH_SKIP;
            end
          end
          PH_DATA: begin
            sdaDriveLow <= cfgAckEnable;
            if (!cfgWaitNinth) begin
              sclHoldLow <= 1'b1;
              waitIrq    <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (fallAck) begin
        sdaDriveLow <= 1'b0;
        unique case (phase)
          PH_ADDR: begin
            phase <= PH_DATA;
            if (addrMatched) begin
              sclHoldLow <= 1'b1;
              waitIrq    <= 1'b1;
            end
          end
          PH_DATA: begin
            if (cfgWaitNinth) begin
              sclHoldLow <= 1'b1;
              waitIrq    <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end

endmodule

// File: rtl/i2c_wait_slave.sv
module i2c_wait_slave
  import i2cws_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_BITS   = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic                 cfgEnable,
  input  logic                 cfgWaitNinth,
  input  logic                 cfgAckEnable,
  input  logic                 cfgStopIrqEn,
  input  logic                 cfgWakeMode,
  input  logic [ADDR_BITS-1:0] localAddr,
  input  logic                 waitRelease,
  output logic                 sdaDriveLow,
  output logic                 sclHoldLow,
  output logic                 waitIrq,
  output logic                 stopIrq,
  output logic [ADDR_BITS:0]   rxByte
);
  localparam int CNT_W = $clog2(ADDR_BITS + 3);

  busEvents_t           events;
  ctlStrobes_t          strobes;
  logic [CNT_W-1:0]     riseCnt;
  logic [ADDR_BITS-1:0] addrField;

  i2cws_datapath #(.SYNC_STAGES(SYNC_STAGES), .ADDR_BITS(ADDR_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strobes(strobes), .events(events), .riseCnt(riseCnt),
    .addrField(addrField), .rxByte(rxByte)
  );

  i2cws_control #(.ADDR_BITS(ADDR_BITS)) u_ctl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgWaitNinth(cfgWaitNinth),
    .cfgAckEnable(cfgAckEnable), .cfgStopIrqEn(cfgStopIrqEn), .cfgWakeMode(cfgWakeMode),
    .localAddr(localAddr), .waitRelease(waitRelease), .events(events),
    .riseCnt(riseCnt), .addrField(addrField), .strobes(strobes),
    .sdaDriveLow(sdaDriveLow), .sclHoldLow(sclHoldLow),
    .waitIrq(waitIrq), .stopIrq(stopIrq)
  );

endmodule

// File: rtl/i2cws_checker.sv
module i2cws_checker (
  input logic clk,
  input logic rstN,
  input logic cfgEnable,
  input logic cfgStopIrqEn,
  input logic cfgWakeMode,
  input logic waitRelease,
  input logic sdaDriveLow,
  input logic sclHoldLow,
  input logic waitIrq,
  input logic stopIrq
);

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> (!sdaDriveLow && !sclHoldLow && !waitIrq && !stopIrq)); // R9

  AST_STOP_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgStopIrqEn || cfgWakeMode) |=> !stopIrq); // R8

  AST_HOLD_WITH_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclHoldLow) |-> waitIrq); // R2

  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && sclHoldLow && !waitRelease) |=> sclHoldLow); // R2

  AST_RELEASE_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && waitRelease) |=> !sclHoldLow); // R2

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    waitIrq |=> !waitIrq); // R2

endmodule

bind i2c_wait_slave i2cws_checker u_chk (
  .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgStopIrqEn(cfgStopIrqEn),
  .cfgWakeMode(cfgWakeMode), .waitRelease(waitRelease), .sdaDriveLow(sdaDriveLow),
  .sclHoldLow(sclHoldLow), .waitIrq(waitIrq), .stopIrq(stopIrq)
);

// File: tb/test_i2c_wait_slave.sv
`timescale 1ns/1ps
module test_i2c_wait_slave;
  localparam int PH = 10;
  localparam logic [6:0] MY_ADDR = 7'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic cfgEnable = 1'b0, cfgWaitNinth = 1'b0, cfgAckEnable = 1'b0;
  logic cfgStopIrqEn = 1'b0, cfgWakeMode = 1'b0;
  logic waitRelease = 1'b0;
  logic sdaDriveLow, sclHoldLow, waitIrq, stopIrq;
  logic [7:0] rxByte;
  logic sclBus, sdaBus;

  int compared = 0, mismatched = 0;
  int irqCnt = 0, stopCnt = 0;
  int holdAt;
  logic ackLow;
  logic [7:0] rxAtHold;

  always #2.5 clk = ~clk;

  assign sclBus = sclM & ~sclHoldLow;
  assign sdaBus = sdaM & ~sdaDriveLow;

  i2c_wait_slave i_i2c_wait_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus),
    .cfgEnable(cfgEnable), .cfgWaitNinth(cfgWaitNinth), .cfgAckEnable(cfgAckEnable),
    .cfgStopIrqEn(cfgStopIrqEn), .cfgWakeMode(cfgWakeMode), .localAddr(MY_ADDR),
    .waitRelease(waitRelease), .sdaDriveLow(sdaDriveLow), .sclHoldLow(sclHoldLow),
    .waitIrq(waitIrq), .stopIrq(stopIrq), .rxByte(rxByte)
  );

  always @(posedge clk) begin
    if (waitIrq) irqCnt <= irqCnt + 1;
    if (stopIrq) stopCnt <= stopCnt + 1;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doStart();
    sdaM = 1'b1; step(PH);
    sclM = 1'b1; step(PH);
    sdaM = 1'b0; step(PH);
    sclM = 1'b0; step(PH);
  endtask

  task automatic doStop();
    sdaM = 1'b0; step(PH);
    sclM = 1'b1; step(PH);
    sdaM = 1'b1; step(PH);
  endtask

  // one SCL pulse; records ack sampled on clock 9 and any stretch after the fall
  task automatic clockBit(input logic b, input int idx);
    sdaM = b; step(PH);
    sclM = 1'b1; step(PH);
    if (idx == 9) ackLow = ~sdaBus;
    sclM = 1'b0; step(PH);
    if (sclHoldLow) begin
      holdAt = idx;
      rxAtHold = rxByte;
      step(4);
      waitRelease = 1'b1; step(1);
      waitRelease = 1'b0; step(2);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output int irqs);
    int irq0;
    irq0 = irqCnt;
    holdAt = 0;
    ackLow = 1'b0;
    rxAtHold = 8'h00;
    for (int i = 7; i >= 0; i--) clockBit(b[i], 8 - i);
    clockBit(1'b1, 9);
    irqs = irqCnt - irq0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    int irqs, stop0, expHold, expAck, expIrq;
    logic [7:0] addrByte, dataByte;
    step(5);
    // reset state
    check("R9 reset sda", sdaDriveLow, 0);
    check("R9 reset scl", sclHoldLow, 0);
    check("R10 reset rxByte", rxByte, 0);
    rstN = 1'b1;
    step(5);
    cfgEnable = 1'b1;
    step(5);

    for (int ws = 0; ws < 2; ws++) begin
      for (int ae = 0; ae < 2; ae++) begin
        for (int kind = 0; kind < 4; kind++) begin
          cfgWaitNinth = ws[0];
          cfgAckEnable = ae[0];
          cfgStopIrqEn = kind[0];
          cfgWakeMode  = kind[1];
          case (kind)
            0: addrByte = {MY_ADDR, 1'b0};
            1: addrByte = {MY_ADDR, 1'b1};
            2: addrByte = 8'hF2;
            default: addrByte = 8'h36;
          endcase
          dataByte = 8'hA5 ^ 8'(ws * 37 + ae * 11 + kind * 70);
          doStart();
          sendByte(addrByte, irqs);
          if (kind < 2) begin
            check("R3 addr hold edge", holdAt, 9);
            check("R3 addr ack", ackLow, 1);
            check("R3 addr irq", irqs, 1);
            check("R10 addr byte", rxAtHold, addrByte);
          end else if (kind == 2) begin
            check("R4 ext hold edge", holdAt, 8);
            check("R4 ext ack", ackLow, ae);
            check("R4 ext irq", irqs, 1);
          end else begin
            check("R5 foreign hold", holdAt, 0);
            check("R5 foreign ack", ackLow, 0);
            check("R5 foreign irq", irqs, 0);
          end
          sendByte(dataByte, irqs);
          expHold = (kind == 3) ? 0 : (ws ? 9 : 8);
          expAck  = (kind == 3) ? 0 : ae;
          expIrq  = (kind == 3) ? 0 : 1;
          check(kind == 3 ? "R5 data hold" : "R6 data hold edge", holdAt, expHold);
          check(kind == 3 ? "R5 data ack" : "R7 data ack", ackLow, expAck);
          check(kind == 3 ? "R5 data irq" : "R6 data irq", irqs, expIrq);
          if (kind != 3) check("R10 data byte", rxAtHold, dataByte);
          stop0 = stopCnt;
          doStop();
          step(6);
          check("R8 stop irq", stopCnt - stop0, (kind == 1) ? 1 : 0);
          check("R1 idle after stop sda", sdaDriveLow, 0);
        end
      end
    end

    // R1: repeated start mid-byte restarts address reception
    cfgWaitNinth = 1'b0; cfgAckEnable = 1'b0; cfgStopIrqEn = 1'b1; cfgWakeMode = 1'b0;
    doStart();
    sendByte({MY_ADDR, 1'b0}, irqs);
    clockBit(1'b0, 1); clockBit(1'b1, 2); clockBit(1'b1, 3);
    doStart();
    sendByte({MY_ADDR, 1'b1}, irqs);
    check("R1 restart hold edge", holdAt, 9);
    check("R1 restart ack", ackLow, 1);
    check("R1 restart byte", rxAtHold, {MY_ADDR, 1'b1});
    stop0 = stopCnt;
    doStop();
    step(6);
    check("R1 stop seen", stopCnt - stop0, 1);

    // R9: disabled interface ignores everything
    cfgEnable = 1'b0; cfgAckEnable = 1'b1; cfgWaitNinth = 1'b1;
    step(5);
    doStart();
    sendByte({MY_ADDR, 1'b0}, irqs);
    check("R9 off hold", holdAt, 0);
    check("R9 off ack", ackLow, 0);
    check("R9 off irq", irqs, 0);
    sendByte(8'h5A, irqs);
    check("R9 off data ack", ackLow, 0);
    stop0 = stopCnt;
    doStop();
    step(6);
    check("R9 off stop irq", stopCnt - stop0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule